// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning Interrupt

This block is a free-running supervisor counter clocked by the system clock. Once software has armed it, it counts clock cycles. When the count reaches one of four power-of-two limits, it first sets a sticky warning flag, which can also drive an interrupt request. If software does not restart the counter, the block emits a one-clock system reset pulse a fixed number of clocks after the warning.

Software reaches the block through a narrow write-only bus with two locations: a control register and an unlock register. The limit select, the interrupt enable and the flag-clear command take effect on any write. The arm bit and the restart command are guarded. They are accepted only in a short window that opens after a two-byte key sequence has been written to the unlock register, so stray code cannot silence or feed the watchdog by accident.

The four limit exponents and the warning-to-reset gap are parameters, so a simulation can run with small values.

Top module: `wdt_guard`

## Requirements
- R1: Control register bits [1:0] select the warning limit: code 0, 1, 2 and 3 give 2^EXP0, 2^EXP1, 2^EXP2 and 2^EXP3 clocks. The count starts at the edge that restarts an armed counter. The flag is set after exactly that many further clock edges.
- R2: The reset output is a pulse exactly one clock wide. It rises exactly GAP_CLKS clock edges after the edge that set the flag, provided no restart is accepted in between.
- R3: An accepted restart (control bit 4 written as 1) clears the count and any pending reset. A new full interval then begins, so no warning or reset occurs before it ends.
- R4: The counter advances only while the arm bit (control bit 3) is 1. While the arm bit is 0, the count holds.
- R5: The interrupt output equals flag AND interrupt enable (control bit 2). The reset pulse occurs whatever the interrupt enable holds.
- R6: Writing key 8'h3C and then key 8'hC3 to the unlock register (address 1) opens a window. A control write (address 0) in any of the next 3 clock cycles updates the arm and restart bits. Outside the window those two bits are ignored, while bits [2:0] and bit 5 still take effect.
- R7: Only one guarded write is accepted per window. Any bus write other than the expected next key clears the partial key sequence, and any write closes an open window.
- R8: If the limit select is changed after a restart, the next warning uses the new select value, with no early expiry caused by the old one.
- R9: The flag stays set until a control write with bit 5 set to 1 clears it. A restart does not clear the flag.
- R10: The input reset and the block's own reset pulse clear the count, the flag and the arm bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one write per high cycle |
| wr_addr | input | 1 | 0 = control register, 1 = unlock register |
| wr_data | input | 8 | Write data |
| irq_o | output | 1 | Interrupt request (flag AND interrupt enable) |
| flag_o | output | 1 | Sticky warning flag |
| wdrst_o | output | 1 | One-clock system reset pulse |

## Verification
The hardest situation to reach from the ports is the edge of the unlock window. A guarded write must land on the last accepted cycle in one run and one cycle too late in another, with the exact number of idle cycles after the second key. The bench drives writes back to back from the falling edge, places a chosen number of idle cycles between the key and the control write, and then times the warning from the accepting edge. A write that is accepted by mistake shows up as a warning that appears early, late or not at all. The same timing method exposes a restart issued in the warning-to-reset gap and a select change made right after a restart.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] KEY_FIRST  = 8'h3C;
  localparam logic [7:0] KEY_SECOND = 8'hC3;
  localparam int         WIN_CLKS   = 3;
  localparam int         B_IE       = 2;
  localparam int         B_ARM      = 3;
  localparam int         B_RESTART  = 4;
  localparam int         B_CLR      = 5;
  localparam logic       A_CTRL     = 1'b0;
  localparam logic       A_UNLOCK   = 1'b1;
endpackage

// File: rtl/wdt_access.sv
module wdt_access
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fire,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  output logic [1:0] tsel,
  output logic       ie,
  output logic       arm,
  output logic       restart,
  output logic       clr
);
  localparam int WW = $clog2(WIN_CLKS + 1);

  logic          key_seen;
  logic [WW-1:0] win;
  logic          ctrl_wr;
  logic          open_w;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign open_w  = (win != '0);
  assign restart = ctrl_wr && open_w && wr_data[B_RESTART];
  assign clr     = ctrl_wr && wr_data[B_CLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      key_seen <= 1'b0;
      win      <= '0;
      tsel     <= 2'b00;
      ie       <= 1'b0;
      arm      <= 1'b0;
    end else begin
      if (open_w) win <= win - 1'b1;
      if (wr_en) begin
        key_seen <= 1'b0;
        win      <= '0;
        if (wr_addr == A_UNLOCK) begin
          if (wr_data == KEY_FIRST) key_seen <= 1'b1;
          else if (wr_data == KEY_SECOND && key_seen) win <= WW'(WIN_CLKS);
        end else begin
          tsel <= wr_data[1:0];
          ie   <= wr_data[B_IE];
          if (open_w) arm <= wr_data[B_ARM];
        end
      end
      if (fire) begin
        arm      <= 1'b0;
        win      <= '0;
        key_seen <= 1'b0;
      end
    end
  end

  // R6
  guard_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !open_w && !fire) |=> (arm == $past(arm)));

  // R7
  win_range_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && open_w) |=> (win == '0));
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int EXP0     = 17,
  parameter int EXP1     = 20,
  parameter int EXP2     = 23,
  parameter int EXP3     = 26,
  parameter int GAP_CLKS = 512
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] tsel,
  input  logic       arm,
  input  logic       restart,
  input  logic       clr,
  output logic       fire,
  output logic       flag,
  output logic       rst_pulse
);
  localparam int EMAX = (EXP0 > EXP1 ? EXP0 : EXP1) > (EXP2 > EXP3 ? EXP2 : EXP3)
                      ? (EXP0 > EXP1 ? EXP0 : EXP1) : (EXP2 > EXP3 ? EXP2 : EXP3);
  localparam int CW = EMAX + 1;
  localparam int GW = $clog2(GAP_CLKS + 1);
  localparam int EXPS [4] = '{EXP0, EXP1, EXP2, EXP3};

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic [GW-1:0] gap;
  logic          expired;
  logic          hit;

  always_comb begin
    lim = (CW'(1) << EXPS[tsel]) - CW'(1);
  end

  assign hit  = arm && !restart && !expired && (cnt >= lim);
  assign fire = arm && !restart && expired && (gap == GW'(GAP_CLKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      gap       <= '0;
      expired   <= 1'b0;
      flag      <= 1'b0;
      rst_pulse <= 1'b0;
    end else begin
      rst_pulse <= fire;
      if (fire) begin
        cnt     <= '0;
        gap     <= '0;
        expired <= 1'b0;
        flag    <= 1'b0;
      end else begin
        if (restart) begin
          cnt     <= '0;
          gap     <= '0;
          expired <= 1'b0;
        end else if (arm) begin
          if (expired)  gap     <= gap + 1'b1;
          else if (hit) expired <= 1'b1;
          else          cnt     <= cnt + 1'b1;
        end
        if (hit)      flag <= 1'b1;
        else if (clr) flag <= 1'b0;
      end
    end
  end

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    rst_pulse |=> !rst_pulse);

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> (flag || rst_pulse));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!arm && !restart) |=> $stable(cnt));

  // R3
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0 && !expired && !rst_pulse));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard #(
  parameter int EXP0     = 17,
  parameter int EXP1     = 20,
  parameter int EXP2     = 23,
  parameter int EXP3     = 26,
  parameter int GAP_CLKS = 512
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  output logic       irq_o,
  output logic       flag_o,
  output logic       wdrst_o
);
  logic [1:0] tsel;
  logic       ie, arm, restart, clr, fire, flag, rst_pulse;

  wdt_access u_acc (
    .clk(clk), .rst(rst), .fire(fire), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tsel(tsel), .ie(ie), .arm(arm), .restart(restart), .clr(clr)
  );

  wdt_count #(
    .EXP0(EXP0), .EXP1(EXP1), .EXP2(EXP2), .EXP3(EXP3), .GAP_CLKS(GAP_CLKS)
  ) u_cnt (
    .clk(clk), .rst(rst), .tsel(tsel), .arm(arm), .restart(restart), .clr(clr),
    .fire(fire), .flag(flag), .rst_pulse(rst_pulse)
  );

  assign flag_o  = flag;
  assign irq_o   = flag & ie;
  assign wdrst_o = rst_pulse;

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag_o);
endmodule

// File: tb/sim_wdt_guard.sv
`timescale 1ns/1ps
module sim_wdt_guard;
  localparam int EXPS [4] = '{4, 5, 6, 7};
  localparam int GAP = 8;
  localparam logic [2:0] VEC [4] = '{3'b1_00, 3'b0_01, 3'b1_10, 3'b0_11};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic irq_o, flag_o, wdrst_o;
  int total = 0;
  int bad = 0;
  int n;

  wdt_guard #(.EXP0(EXPS[0]), .EXP1(EXPS[1]), .EXP2(EXPS[2]), .EXP3(EXPS[3]),
              .GAP_CLKS(GAP)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_o(irq_o), .flag_o(flag_o), .wdrst_o(wdrst_o));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [7:0] cb(input logic [1:0] s, input bit ie, input bit en,
                                    input bit rs, input bit cl);
    return {2'b00, cl, rs, en, ie, s};
  endfunction

  task automatic unlock();
    wr(1'b1, 8'h3C);
    wr(1'b1, 8'hC3);
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
  endtask

  task automatic to_flag(output int c);
    c = 0;
    while (!flag_o && c < 2000) begin
      @(negedge clk);
      c++;
    end
  endtask

  task automatic to_rst(output int c);
    c = 0;
    while (!wdrst_o && c < 2000) begin
      @(negedge clk);
      c++;
    end
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog timeout actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R10 reset state
    chk(flag_o == 0 && irq_o == 0 && wdrst_o == 0, "R10", flag_o, 0);

    // R1 R2 R5 R10 table walk
    for (int i = 0; i < 4; i++) begin
      logic [1:0] s;
      bit ie;
      s = VEC[i][1:0];
      ie = VEC[i][2];
      do_reset();
      unlock();
      wr(1'b0, cb(s, ie, 1, 1, 0));
      to_flag(n);
      chk(n == (1 << EXPS[s]), "R1", n, 1 << EXPS[s]);
      chk(irq_o == ie, "R5", irq_o, ie);
      to_rst(n);
      chk(n == GAP, "R2", n, GAP);
      @(negedge clk);
      chk(wdrst_o == 0, "R2", wdrst_o, 0);
      chk(flag_o == 0, "R10", flag_o, 0);
    end

    // R4 not armed: no counting
    do_reset();
    idle(40);
    chk(flag_o == 0, "R4", flag_o, 0);
    // R4 disarm mid-count holds
    unlock();
    wr(1'b0, cb(0, 1, 1, 1, 0));
    idle(5);
    unlock();
    wr(1'b0, cb(0, 1, 0, 0, 0));
    idle(40);
    chk(flag_o == 0, "R4", flag_o, 0);

    // R6 unguarded arm write ignored
    do_reset();
    wr(1'b0, cb(0, 1, 1, 1, 0));
    idle(40);
    chk(flag_o == 0, "R6", flag_o, 0);

    // R7 broken key sequence
    do_reset();
    wr(1'b1, 8'h3C);
    wr(1'b0, cb(0, 1, 0, 0, 0));
    wr(1'b1, 8'hC3);
    wr(1'b0, cb(0, 1, 1, 1, 0));
    idle(40);
    chk(flag_o == 0, "R7", flag_o, 0);

    // R6 window expired after 3 idle cycles
    do_reset();
    unlock();
    idle(3);
    wr(1'b0, cb(0, 1, 1, 1, 0));
    idle(40);
    chk(flag_o == 0, "R6", flag_o, 0);

    // R6 last accepted cycle (2 idle)
    do_reset();
    unlock();
    idle(2);
    wr(1'b0, cb(0, 1, 1, 1, 0));
    to_flag(n);
    chk(n == 16, "R6", n, 16);

    // R7 second guarded write in same window rejected
    do_reset();
    unlock();
    wr(1'b0, cb(0, 1, 1, 1, 0));
    wr(1'b0, cb(0, 1, 0, 0, 0));
    to_flag(n);
    chk(n + 1 == 16, "R7", n + 1, 16);

    // R3 restart before warning delays it
    do_reset();
    unlock();
    wr(1'b0, cb(0, 1, 1, 1, 0));
    idle(12);
    unlock();
    wr(1'b0, cb(0, 1, 1, 1, 0));
    to_flag(n);
    chk(n == 16, "R3", n, 16);
    // R3 R9 restart in gap cancels reset, flag stays
    idle(3);
    unlock();
    wr(1'b0, cb(0, 1, 1, 1, 0));
    idle(GAP + 4);
    chk(wdrst_o == 0, "R3", wdrst_o, 0);
    chk(flag_o == 1, "R9", flag_o, 1);
    // R9 clear via bit 5
    wr(1'b0, cb(0, 1, 0, 0, 1));
    chk(flag_o == 0, "R9", flag_o, 0);

    // R8 select change after restart
    do_reset();
    unlock();
    wr(1'b0, cb(3, 1, 1, 1, 0));
    idle(20);
    unlock();
    wr(1'b0, cb(3, 1, 1, 1, 0));
    wr(1'b0, cb(0, 1, 0, 0, 0));
    to_flag(n);
    chk(n + 1 == 16, "R8", n + 1, 16);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule